// File: doc/BRIEF.md
# Two-Stage Saturating Multiply-Accumulate Unit

This block multiplies signed two's complement operands and either returns the product or adds it to an internal accumulator that has guard bits above the product width. Each operation takes two clock cycles. The first stage only forms the partial products and compresses them into a redundant sum/carry pair. The second stage merges that pair with the accumulator and with a sign-correction constant. It then performs the single carry-propagate addition and clamps the result to the accumulator range.

A two-bit mode input selects the shape of the operation: one full-width multiply, one half-width multiply on the low operand halves, or two independent half-width multiplies side by side. In dual mode the accumulator is split into two lanes, and neither partial products nor carries cross between the lanes. A per-operation control selects plain multiply or multiply-accumulate. A clear input makes a multiply-accumulate load the new product instead of adding it. Operations may be issued on every cycle.

Top module: `satMacPipe`

## Requirements
- R1: While reset is asserted and after it is released with no operation issued, `resultValid` is 0 and `result` is 0.
- R2: An operation accepted on a clock edge with `inValid` high produces exactly one cycle of `resultValid` high, two clock edges later. `resultValid` is never high otherwise.
- R3: Mode 2'b00 with `opMac`=0 returns the signed product `opA*opB` (16x16 bits), sign-extended to the 40-bit `result`. This includes the most negative operand values.
- R4: With `opMac`=1 and `clearAcc`=0, the new accumulator is the old accumulator plus the product, and `result` shows the new accumulator.
- R5: With `opMac`=1 and `clearAcc`=1, the accumulator is loaded with the product alone.
- R6: A plain multiply (`opMac`=0) leaves the accumulator unchanged, so a later multiply-accumulate continues from the earlier value.
- R7: In full and half modes the accumulator saturates to 2^39-1 when a sum would exceed it, and to -2^39 when a sum would fall below it.
- R8: Mode 2'b01 multiplies the signed 8-bit values `opA[7:0]` and `opB[7:0]`, accumulating at the full 40-bit width. `opA[15:8]` and `opB[15:8]` have no effect.
- R9: Mode 2'b10 runs two independent 8x8 signed lanes. Lane 0 uses `opA[7:0]`, `opB[7:0]` and `result[19:0]`; lane 1 uses `opA[15:8]`, `opB[15:8]` and `result[39:20]`. Each lane accumulates and saturates within its own signed 20-bit range, and no carry crosses between the lanes.
- R10: Mode 2'b11 behaves exactly like mode 2'b00.
- R11: Operations issued on consecutive cycles each see the accumulator left by the one before.
- R12: `result` holds its value on every cycle on which `resultValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and controls are valid this cycle |
| modeSel | input | 2 | 00 full, 01 single half-width, 10 dual half-width, 11 full |
| opMac | input | 1 | 1 accumulate, 0 plain multiply |
| clearAcc | input | 1 | With opMac, load the product instead of adding it |
| opA | input | 16 | Multiplicand, or two packed half-width multiplicands |
| opB | input | 16 | Multiplier, or two packed half-width multipliers |
| resultValid | output | 1 | Result of an operation issued two cycles earlier |
| result | output | 40 | Saturated accumulator value or product |

## Verification
The bench uses the default 16-bit operands and 8 guard bits. With these values the accumulator and each dual lane sit only nine and five bits above the largest product. A run of about five hundred full-width operations, or about forty dual-lane operations, therefore drives the sum past either limit, and both saturation directions fit in a short run. The same widths keep the products of the most negative operands, the lane boundary at bit 20 and the sign-correction constants for both operand sizes within reach of directed and random stimulus in every mode.

// File: rtl/satMacPkg.sv
package satMacPkg;

  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_HALF = 2'b01,
    MODE_DUAL = 2'b10,
    MODE_ALTF = 2'b11
  } macMode_e;

  // strobes for the compression stage, decoded in the issue cycle
  typedef struct packed {
    logic capture;
    logic laneSplit;
    logic halfOnly;
  } s1Strobe_t;

  // strobes for the merge stage, registered alongside the carry-save pair
  typedef struct packed {
    logic fire;
    logic laneSplit;
    logic halfOnly;
    logic useAcc;
    logic writeAcc;
  } s2Strobe_t;

endpackage

// File: rtl/satMacCtrl.sv
module satMacCtrl
  import satMacPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic [1:0] modeSel,
  input  logic      opMac,
  input  logic      clearAcc,
  output s1Strobe_t s1Strb,
  output s2Strobe_t s2Strb
);

  logic splitNow;
  logic halfNow;

  always_comb begin
    splitNow = (modeSel == MODE_DUAL);
    halfNow  = (modeSel == MODE_HALF);
    s1Strb.capture   = inValid;
    s1Strb.laneSplit = splitNow;
    s1Strb.halfOnly  = halfNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Strb <= '0;
    end else begin
      s2Strb.fire <= inValid;
      if (inValid) begin
        s2Strb.laneSplit <= splitNow;
        s2Strb.halfOnly  <= halfNow;
        s2Strb.useAcc    <= opMac & ~clearAcc;
        s2Strb.writeAcc  <= opMac;
      end
    end
  end

endmodule

// File: rtl/satMacStage1.sv
module satMacStage1
  import satMacPkg::*;
#(
  parameter int OP_W   = 16,
  parameter int LANE_W = 20,
  parameter int WIDE_W = 42
) (
  input  logic              clk,
  input  logic              rstN,
  input  s1Strobe_t         s1Strb,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [WIDE_W-1:0] sumQ,
  output logic [WIDE_W-1:0] carryQ
);

  localparam int HALF_W = OP_W / 2;

  function automatic int rowsAt(input int lvl);
    int n;
    n = OP_W;
    for (int k = 0; k < lvl; k++) n = 2 * (n / 3) + (n % 3);
    return n;
  endfunction

  function automatic int levelCount();
    int n;
    int l;
    n = OP_W;
    l = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + (n % 3);
      l++;
    end
    return l;
  endfunction

  localparam int LEVELS = levelCount();

  logic [WIDE_W-1:0] fullRow [OP_W];
  logic [WIDE_W-1:0] laneRow [OP_W];
  logic [WIDE_W-1:0] ppRow   [OP_W];
  logic [WIDE_W-1:0] killMask;

  // Partial products in the sign-corrected form: bits that pair one sign
  // bit with one magnitude bit are inverted; the matching constant is
  // added in stage two.
  always_comb begin
    for (int i = 0; i < OP_W; i++) begin
      fullRow[i] = '0;
      laneRow[i] = '0;
      for (int j = 0; j < OP_W; j++) begin
        fullRow[i][i+j] = (opA[j] & opB[i]) ^ ((i == OP_W-1) != (j == OP_W-1));
      end
      if (i < HALF_W) begin
        for (int j = 0; j < HALF_W; j++) begin
          laneRow[i][i+j] = (opA[j] & opB[i]) ^ ((i == HALF_W-1) != (j == HALF_W-1));
        end
      end else begin
        for (int j = 0; j < HALF_W; j++) begin
          laneRow[i][LANE_W+1+(i-HALF_W)+j] =
            (opA[HALF_W+j] & opB[i]) ^ (((i-HALF_W) == HALF_W-1) != (j == HALF_W-1));
        end
      end
    end
    for (int i = 0; i < OP_W; i++) begin
      if (s1Strb.laneSplit)     ppRow[i] = laneRow[i];
      else if (s1Strb.halfOnly) ppRow[i] = (i < HALF_W) ? laneRow[i] : '0;
      else                      ppRow[i] = fullRow[i];
    end
  end

  // carries must not enter lane one from lane zero in dual mode
  assign killMask = s1Strb.laneSplit ? (WIDE_W'(1) << (LANE_W+1)) : '0;

  logic [WIDE_W-1:0] tree [LEVELS+1][OP_W];

  for (genvar k = 0; k < OP_W; k++) begin : g_seed
    assign tree[0][k] = ppRow[k];
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int CUR = rowsAt(lv);
    localparam int GRP = CUR / 3;
    localparam int NXT = rowsAt(lv + 1);
    for (genvar k = 0; k < OP_W; k++) begin : g_row
      if (k < 2 * GRP) begin : g_csa
        if (k % 2 == 0) begin : g_sum
          assign tree[lv+1][k] = tree[lv][3*(k/2)] ^ tree[lv][3*(k/2)+1] ^ tree[lv][3*(k/2)+2];
        end else begin : g_cry
          assign tree[lv+1][k] =
            (((tree[lv][3*(k/2)] & tree[lv][3*(k/2)+1]) |
              (tree[lv][3*(k/2)] & tree[lv][3*(k/2)+2]) |
              (tree[lv][3*(k/2)+1] & tree[lv][3*(k/2)+2])) << 1) & ~killMask;
        end
      end else if (k < NXT) begin : g_pass
        assign tree[lv+1][k] = tree[lv][3*GRP + (k - 2*GRP)];
      end else begin : g_zero
        assign tree[lv+1][k] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ   <= '0;
      carryQ <= '0;
    end else if (s1Strb.capture) begin
      sumQ   <= tree[LEVELS][0];
      carryQ <= tree[LEVELS][1];
    end
  end

endmodule

// File: rtl/satMacStage2.sv
module satMacStage2
  import satMacPkg::*;
#(
  parameter int OP_W   = 16,
  parameter int ACC_W  = 40,
  parameter int LANE_W = 20,
  parameter int WIDE_W = 42
) (
  input  logic              clk,
  input  logic              rstN,
  input  s2Strobe_t         s2Strb,
  input  logic [WIDE_W-1:0] sumQ,
  input  logic [WIDE_W-1:0] carryQ,
  output logic [ACC_W-1:0]  result,
  output logic              resultValid
);

  localparam int HALF_W = OP_W / 2;
  localparam int SEG_W  = LANE_W + 1;

  // negated total weight of the inverted partial-product bits of an m x m product
  function automatic logic [WIDE_W-1:0] signFix(input int m);
    logic [WIDE_W-1:0] weight;
    weight = (WIDE_W'(1) << (2*m-1)) - (WIDE_W'(1) << m);
    return ~weight + WIDE_W'(1);
  endfunction

  localparam logic [WIDE_W-1:0] FULL_FIX = signFix(OP_W);
  localparam logic [WIDE_W-1:0] HALF_FIX = signFix(HALF_W);
  localparam logic [WIDE_W-1:0] DUAL_FIX = {HALF_FIX[LANE_W:0], HALF_FIX[LANE_W:0]};

  logic [ACC_W-1:0]  accQ;
  logic [WIDE_W-1:0] accExt, fixSel, killMask;
  logic [WIDE_W-1:0] mSum, mCry, fSum, fCry, total;
  logic [SEG_W:0]    lowSum;
  logic [SEG_W-1:0]  highSum;
  logic [ACC_W-1:0]  satFull, satDual, nextVal;

  always_comb begin
    if (!s2Strb.useAcc)       accExt = '0;
    else if (s2Strb.laneSplit) accExt = {accQ[ACC_W-1], accQ[ACC_W-1:LANE_W],
                                         accQ[LANE_W-1], accQ[LANE_W-1:0]};
    else                       accExt = {{2{accQ[ACC_W-1]}}, accQ};

    if (s2Strb.laneSplit)     fixSel = DUAL_FIX;
    else if (s2Strb.halfOnly) fixSel = HALF_FIX;
    else                      fixSel = FULL_FIX;

    killMask = s2Strb.laneSplit ? (WIDE_W'(1) << SEG_W) : '0;
  end

  // two carry-save levels: pair + constant, then + accumulator
  assign mSum = sumQ ^ carryQ ^ fixSel;
  assign mCry = (((sumQ & carryQ) | (sumQ & fixSel) | (carryQ & fixSel)) << 1) & ~killMask;
  assign fSum = mSum ^ mCry ^ accExt;
  assign fCry = (((mSum & mCry) | (mSum & accExt) | (mCry & accExt)) << 1) & ~killMask;

  // one carry-propagate adder, cut at the lane boundary in dual mode
  assign lowSum  = {1'b0, fSum[SEG_W-1:0]} + {1'b0, fCry[SEG_W-1:0]};
  assign highSum = fSum[WIDE_W-1:SEG_W] + fCry[WIDE_W-1:SEG_W]
                 + SEG_W'(~s2Strb.laneSplit & lowSum[SEG_W]);
  assign total   = {highSum, lowSum[SEG_W-1:0]};

  always_comb begin
    if (total[ACC_W] != total[ACC_W-1])
      satFull = total[ACC_W] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
    else
      satFull = total[ACC_W-1:0];
  end

  for (genvar l = 0; l < 2; l++) begin : g_lane
    logic [SEG_W-1:0] seg;
    assign seg = total[l*SEG_W +: SEG_W];
    assign satDual[l*LANE_W +: LANE_W] =
      (seg[LANE_W] == seg[LANE_W-1]) ? seg[LANE_W-1:0] :
      (seg[LANE_W] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}});
  end

  assign nextVal = s2Strb.laneSplit ? satDual : satFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ        <= '0;
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= s2Strb.fire;
      if (s2Strb.fire) begin
        result <= nextVal;
        if (s2Strb.writeAcc) accQ <= nextVal;
      end
    end
  end

endmodule

// File: rtl/satMacPipe.sv
module satMacPipe
  import satMacPkg::*;
#(
  parameter int OP_W    = 16,
  parameter int GUARD_W = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic [1:0]                  modeSel,
  input  logic                        opMac,
  input  logic                        clearAcc,
  input  logic [OP_W-1:0]             opA,
  input  logic [OP_W-1:0]             opB,
  output logic                        resultValid,
  output logic [2*OP_W+GUARD_W-1:0]   result
);

  localparam int ACC_W  = 2 * OP_W + GUARD_W;
  localparam int LANE_W = ACC_W / 2;
  localparam int WIDE_W = ACC_W + 2;

  s1Strobe_t         s1Strb;
  s2Strobe_t         s2Strb;
  logic [WIDE_W-1:0] sumQ;
  logic [WIDE_W-1:0] carryQ;

  satMacCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .modeSel  (modeSel),
    .opMac    (opMac),
    .clearAcc (clearAcc),
    .s1Strb   (s1Strb),
    .s2Strb   (s2Strb)
  );

  satMacStage1 #(.OP_W(OP_W), .LANE_W(LANE_W), .WIDE_W(WIDE_W)) stage1_i (
    .clk    (clk),
    .rstN   (rstN),
    .s1Strb (s1Strb),
    .opA    (opA),
    .opB    (opB),
    .sumQ   (sumQ),
    .carryQ (carryQ)
  );

  satMacStage2 #(.OP_W(OP_W), .ACC_W(ACC_W), .LANE_W(LANE_W), .WIDE_W(WIDE_W)) stage2_i (
    .clk         (clk),
    .rstN        (rstN),
    .s2Strb      (s2Strb),
    .sumQ        (sumQ),
    .carryQ      (carryQ),
    .result      (result),
    .resultValid (resultValid)
  );

endmodule

// File: rtl/satMacPipeChk.sv
module satMacPipeChk #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       modeSel,
  input logic             opMac,
  input logic [ACC_W-1:0] result,
  input logic             resultValid
);

  localparam int HALF_W = OP_W / 2;

  logic [1:0] sinceRst;
  logic       histOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end
  assign histOk = (sinceRst >= 2'd2);

  // R2: valid output follows accepted input by exactly two edges
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    histOk |-> (resultValid == $past(inValid, 2)));

  // R12: output register frozen while no result is delivered
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && !resultValid) |-> $stable(result));

  // R3: a full-width plain multiply fits the product range
  a_r3_mul_range: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && resultValid && !$past(opMac, 2) &&
     ($past(modeSel, 2) == 2'b00 || $past(modeSel, 2) == 2'b11))
    |-> (result[ACC_W-1:2*OP_W-1] == '0 || result[ACC_W-1:2*OP_W-1] == '1));

  // R8: a single half-width plain multiply fits the short product range
  a_r8_half_range: assert property (@(posedge clk) disable iff (!rstN)
    (histOk && resultValid && !$past(opMac, 2) && $past(modeSel, 2) == 2'b01)
    |-> (result[ACC_W-1:2*HALF_W-1] == '0 || result[ACC_W-1:2*HALF_W-1] == '1));

endmodule

bind satMacPipe satMacPipeChk #(.OP_W(OP_W), .ACC_W(ACC_W)) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .inValid     (inValid),
  .modeSel     (modeSel),
  .opMac       (opMac),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/satMacPipe_tb_top.sv
module satMacPipe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OP_W   = 16;
  localparam int GUARD_W = 8;
  localparam int ACC_W  = 2 * OP_W + GUARD_W;
  localparam int LANE_W = ACC_W / 2;
  localparam int HALF_W = OP_W / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [1:0]       modeSel = 2'b00;
  logic             opMac = 1'b0;
  logic             clearAcc = 1'b0;
  logic [OP_W-1:0]  opA = '0;
  logic [OP_W-1:0]  opB = '0;
  logic             resultValid;
  logic [ACC_W-1:0] result;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [ACC_W-1:0] accModel = '0;
  logic [ACC_W-1:0] lastRes = '0;
  logic [ACC_W-1:0] expQ[$];
  int               cycQ[$];
  string            tagQ[$];

  satMacPipe #(.OP_W(OP_W), .GUARD_W(GUARD_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeSel(modeSel),
    .opMac(opMac), .clearAcc(clearAcc), .opA(opA), .opB(opB),
    .resultValid(resultValid), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint sx(input longint v, input int w);
    longint t;
    t = v <<< (64 - w);
    return t >>> (64 - w);
  endfunction

  function automatic longint clampTo(input longint v, input int w);
    longint hi, lo;
    hi = (64'sd1 <<< (w - 1)) - 1;
    lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // behavioural reference: computes the expected output at issue time
  task automatic issue(input logic [1:0] m, input bit mac, input bit clr,
                       input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input string tag);
    logic [ACC_W-1:0] nxt;
    longint p, base, s;
    @(negedge clk);
    inValid = 1'b1; modeSel = m; opMac = mac; clearAcc = clr; opA = a; opB = b;
    if (m == 2'b10) begin
      for (int l = 0; l < 2; l++) begin
        p = sx(longint'(a[l*HALF_W +: HALF_W]), HALF_W) * sx(longint'(b[l*HALF_W +: HALF_W]), HALF_W);
        base = (mac && !clr) ? sx(longint'(accModel[l*LANE_W +: LANE_W]), LANE_W) : 0;
        s = clampTo(base + p, LANE_W);
        nxt[l*LANE_W +: LANE_W] = s[LANE_W-1:0];
      end
    end else begin
      if (m == 2'b01) p = sx(longint'(a[HALF_W-1:0]), HALF_W) * sx(longint'(b[HALF_W-1:0]), HALF_W);
      else            p = sx(longint'(a), OP_W) * sx(longint'(b), OP_W);
      base = (mac && !clr) ? sx(longint'(accModel), ACC_W) : 0;
      s = clampTo(base + p, ACC_W);
      nxt = s[ACC_W-1:0];
    end
    if (mac) accModel = nxt;
    expQ.push_back(nxt);
    cycQ.push_back(cyc + 2);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = 16'($urandom);
      opB = 16'($urandom);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      if (cycQ.size() > 0 && cycQ[0] == cyc) begin
        compared++;
        if (resultValid !== 1'b1 || result !== expQ[0]) begin
          mismatched++;
          $display("FAIL %s R2: valid=%b result=%h expected valid=1 result=%h",
                   tagQ[0], resultValid, result, expQ[0]);
        end
        lastRes = expQ[0];
        void'(expQ.pop_front());
        void'(cycQ.pop_front());
        void'(tagQ.pop_front());
      end else begin
        compared++;
        if (resultValid !== 1'b0 || result !== lastRes) begin
          mismatched++;
          $display("FAIL R2/R12 idle: valid=%b result=%h expected valid=0 result=%h",
                   resultValid, result, lastRes);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [OP_W-1:0] ra, rb;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (resultValid !== 1'b0 || result !== '0) begin
      mismatched++;
      $display("FAIL R1: valid=%b result=%h expected valid=0 result=0", resultValid, result);
    end
    rstN = 1'b1;
    running = 1'b1;
    idle(3);

    // R3: corner products, plain multiply, full mode
    issue(2'b00, 0, 0, 16'h8000, 16'h8000, "R3 minxmin");
    issue(2'b00, 0, 0, 16'h8000, 16'h7fff, "R3 minxmax");
    issue(2'b00, 0, 0, 16'h7fff, 16'h7fff, "R3 maxxmax");
    issue(2'b00, 0, 0, 16'hffff, 16'hffff, "R3 -1x-1");
    issue(2'b00, 0, 0, 16'h0000, 16'h8000, "R3 zero");
    issue(2'b00, 0, 0, 16'h7fff, 16'h8000, "R3 maxxmin");
    for (int k = 0; k < 100; k++) issue(2'b00, 0, 0, 16'($urandom), 16'($urandom), "R3 random");
    idle(2);

    // R10: mode 11 as full mode, including accumulate
    for (int k = 0; k < 20; k++) issue(2'b11, 0, 0, 16'($urandom), 16'($urandom), "R10 mul");
    issue(2'b11, 1, 1, 16'h8000, 16'h8000, "R10 clear");
    for (int k = 0; k < 10; k++) issue(2'b11, 1, 0, 16'($urandom), 16'($urandom), "R10 mac");
    idle(2);

    // R5 clear then R4/R11 back-to-back accumulation
    issue(2'b00, 1, 1, 16'd1234, 16'hfedc, "R5 load");
    for (int k = 0; k < 200; k++) issue(2'b00, 1, 0, 16'($urandom), 16'($urandom), "R4 R11 mac");
    idle(3);

    // R6: plain multiply leaves the accumulator alone
    issue(2'b00, 1, 1, 16'd300, 16'd7, "R6 load");
    issue(2'b00, 0, 0, 16'h8000, 16'h8000, "R6 mul");
    issue(2'b00, 1, 0, 16'd5, 16'd11, "R6 continue");
    idle(2);

    // R7: saturate upward then downward
    issue(2'b00, 1, 1, 16'h8000, 16'h8000, "R7 pos load");
    for (int k = 0; k < 520; k++) issue(2'b00, 1, 0, 16'h8000, 16'h8000, "R7 pos run");
    issue(2'b00, 1, 0, 16'h0001, 16'h0001, "R7 pos held");
    issue(2'b00, 1, 1, 16'h8000, 16'h7fff, "R7 neg load");
    for (int k = 0; k < 530; k++) issue(2'b00, 1, 0, 16'h8000, 16'h7fff, "R7 neg run");
    idle(2);

    // R8: single half-width mode, upper bits random
    issue(2'b01, 1, 1, 16'hab80, 16'h5c80, "R8 minxmin");
    for (int k = 0; k < 200; k++) begin
      ra = 16'($urandom); rb = 16'($urandom);
      issue(2'b01, 1'($urandom), 1'($urandom % 8 == 0), ra, rb, "R8 random");
    end
    idle(2);

    // R9: dual lanes, random then saturation in opposite directions
    issue(2'b10, 1, 1, 16'($urandom), 16'($urandom), "R9 load");
    for (int k = 0; k < 200; k++)
      issue(2'b10, 1'($urandom), 1'($urandom % 10 == 0), 16'($urandom), 16'($urandom), "R9 random");
    issue(2'b10, 1, 1, 16'h8080, 16'h7f80, "R9 sat load");
    for (int k = 0; k < 40; k++) issue(2'b10, 1, 0, 16'h8080, 16'h7f80, "R9 sat run");
    issue(2'b10, 1, 1, 16'hff01, 16'h01ff, "R9 boundary load");
    for (int k = 0; k < 5; k++) issue(2'b10, 1, 0, 16'hff01, 16'h01ff, "R9 boundary run");
    idle(2);

    // mixed modes, mixed controls
    for (int k = 0; k < 300; k++) begin
      issue(2'($urandom), 1'($urandom), 1'($urandom % 6 == 0), 16'($urandom), 16'($urandom), "R11 mixed");
      if (k % 37 == 0) idle(1);
    end
    idle(5);
    running = 1'b0;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R2: pending=%0d expected pending=0", expQ.size());
    end
    finishRun();
  end

endmodule